// File: doc/BRIEF.md
# Video Line and Field Counter with Sync Resynchronisation

This block keeps track of where an incoming standard-definition or progressive video stream is in its vertical timing, for a design that runs as a timing slave. It counts lines on the rising edge of the horizontal sync strobe, maintains a field identifier, and emits a one-cycle strobe each time a new field begins. The line number is field-relative: it restarts at 1 at the start of every field. Four standards are selectable: 525-line and 625-line interlaced (two fields per frame, the first field one line longer), and 525-line and 625-line progressive (one field per frame).

Normally the counter runs freely and wraps at the end of each field, without regard to the vertical sync input. When the resynchronisation control is enabled and the slave-mode code is non-zero, the vertical sync rising edge begins the new field instead. A sync that comes early, as in fast-forward trick play, cuts the field short. A sync that comes late, as in rewind, makes the counter wait on the last line. In both cases exactly one field strobe is produced, so downstream logic never sees two competing field boundaries.

A blanking flag is decoded from the line number. With VBI pass disabled, every line of the vertical blanking interval is blanked. With it enabled, a per-standard window of VBI lines is let through and the remainder of the interval stays blanked.

Top module: `vid_field_tracker`

## Requirements
- R1: After synchronous reset (rst_n low at a rising clock edge) the line number is 1, the field identifier is 0 and the end-of-field strobe is low.
- R2: A rising edge of hsync_i is a clock edge at which hsync_i is sampled high after being sampled low at the previous edge. At each such edge the line number increases by one, and the new value is visible after that edge.
- R3: With resynchronisation inactive, the line after the last line of a field is line 1 of the next field. std_sel_i encodes 0 = 525 interlaced (fields of 263 then 262 lines), 1 = 625 interlaced (313 then 312), 2 = 525 progressive (525) and 3 = 625 progressive (625). For the interlaced codes the field identifier toggles at each field start. For the progressive codes it stays 0.
- R4: Resynchronisation is active only when resync_en_i is 1 and slave_mode_i is non-zero. While it is inactive, vsync_i has no effect on the line number, the field identifier or the strobe.
- R5: While resynchronisation is active, a rising edge of vsync_i at any line starts a new field: line 1, field identifier toggled for the interlaced codes, end-of-field strobe high.
- R6: While resynchronisation is active, an hsync_i rising edge at or past the field's last line leaves the line number unchanged and raises no strobe, until a vsync_i rising edge arrives.
- R7: eof_o is high for exactly one clock cycle per field start. If hsync_i and vsync_i rise at the same edge while resynchronisation is active, this produces a single field start at line 1.
- R8: With vbi_pass_i at 0, blank_o is 1 on lines 1 to 20 (code 0), 1 to 22 (code 1), 1 to 42 (code 2) and 1 to 43 (code 3). blank_o is 0 on every later line.
- R9: With vbi_pass_i at 1, blank_o is 0 on lines 10–20 (code 0), 7–22 (code 1), 13–42 (code 2) and 6–43 (code 3). It stays 1 on the other lines of the blanking interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Incoming horizontal sync strobe |
| vsync_i | input | 1 | Incoming vertical sync strobe |
| std_sel_i | input | 2 | Video standard code (see R3) |
| slave_mode_i | input | 2 | Slave timing mode code; 0 disables resync |
| resync_en_i | input | 1 | Follow incoming vertical sync for field start |
| vbi_pass_i | input | 1 | Let the VBI data window through unblanked |
| line_o | output | 10 | Field-relative line number, starting at 1 |
| field_o | output | 1 | Field identifier |
| eof_o | output | 1 | One-cycle pulse at each field start |
| blank_o | output | 1 | Output suppression during vertical blanking |

## Verification
The bench runs early vertical sync at mid-field and late vertical sync after several extra horizontal syncs on the last line. A counter that wrapped on its own during rewind would issue a second field strobe. One that ignored the early sync would carry on counting from line 100. Coincident horizontal and vertical edges are driven to catch a design that restarts twice or advances to line 2. Each end of every VBI window is probed one line inside and one line outside, so an off-by-one in the decode shows up as a wrong blank level. Mode code 0 with resync requested is checked to confirm that vertical sync is ignored and that the counter wraps instead of holding.

// File: rtl/vft_pkg.sv
// Package: shared types and per-standard timing constants for the
// line/field tracker. Assumes field-relative line numbering from 1.
package vft_pkg;

    typedef enum logic [1:0] {
        STD_I525 = 2'd0,
        STD_I625 = 2'd1,
        STD_P525 = 2'd2,
        STD_P625 = 2'd3
    } vid_std_e;

    // True for standards that alternate two fields per frame.
    function automatic logic is_interlaced(vid_std_e s);
        return (s == STD_I525) || (s == STD_I625);
    endfunction

    // Last line of the current field; the first interlaced field is longer.
    function automatic int field_last(vid_std_e s, logic fld);
        case (s)
            STD_I525: return fld ? 262 : 263;
            STD_I625: return fld ? 312 : 313;
            STD_P525: return 525;
            default:  return 625;
        endcase
    endfunction

    // Last line of the vertical blanking interval (also the window end).
    function automatic int vbi_last(vid_std_e s);
        case (s)
            STD_I525: return 20;
            STD_I625: return 22;
            STD_P525: return 42;
            default:  return 43;
        endcase
    endfunction

    // First line of the VBI data window that may pass unblanked.
    function automatic int pass_first(vid_std_e s);
        case (s)
            STD_I525: return 10;
            STD_I625: return 7;
            STD_P525: return 13;
            default:  return 6;
        endcase
    endfunction

endpackage

// File: rtl/vft_edge.sv
// Module: rising-edge detector for a vector of sync strobes.
// Assumes inputs are already synchronous to clk. A strobe held high
// through reset release counts as a rising edge on the first cycle.
module vft_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic d_q;

        // Remember the previous sample of this strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) d_q <= 1'b0;
            else        d_q <= sig_i[i];
        end

        assign rise_o[i] = sig_i[i] & ~d_q;
    end

endmodule

// File: rtl/vft_line_ctr.sv
// Module: field-relative line counter with field identifier and
// end-of-field strobe. In free-run it wraps at the field's last line.
// With resync active, a vertical sync edge starts the field, and
// horizontal syncs at the last line hold the count. Assumes edge
// inputs are single-cycle pulses.
module vft_line_ctr
    import vft_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_rise,
    input  logic              vs_rise,
    input  vid_std_e          std,
    input  logic              resync_act,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o,
    output logic              eof_o
);

    localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

    logic [LINE_W-1:0] line_q, line_n;
    logic              field_q, field_n;
    logic              eof_q, eof_n;
    logic              at_end;

    assign at_end = int'(line_q) >= field_last(std, field_q);

    // Choose the next line, field and strobe from the sync events.
    always_comb begin
        line_n  = line_q;
        field_n = field_q;
        eof_n   = 1'b0;
        if (resync_act && vs_rise) begin
            line_n  = FIRST_LINE;
            field_n = is_interlaced(std) ? ~field_q : 1'b0;
            eof_n   = 1'b1;
        end else if (hs_rise) begin
            if (!at_end) begin
                line_n = line_q + FIRST_LINE;
            end else if (!resync_act) begin
                line_n  = FIRST_LINE;
                field_n = is_interlaced(std) ? ~field_q : 1'b0;
                eof_n   = 1'b1;
            end
        end
    end

    // Register the counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= FIRST_LINE;
            field_q <= 1'b0;
            eof_q   <= 1'b0;
        end else begin
            line_q  <= line_n;
            field_q <= field_n;
            eof_q   <= eof_n;
        end
    end

    assign line_o  = line_q;
    assign field_o = field_q;
    assign eof_o   = eof_q;

    assert_vs_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync_act && !hs_rise) |=> ($stable(line_q) && !eof_q));

    assert_start_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eof_q |-> (line_q == FIRST_LINE));

    assert_rewind_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_act && hs_rise && !vs_rise && at_end) |=> ($stable(line_q) && !eof_q));

    assert_eof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eof_q |=> !eof_q);

    assert_prog_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_interlaced(std) && eof_n) |=> !field_q);

    assert_line_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_q != '0);

endmodule

// File: rtl/vft_blank.sv
// Module: decodes the vertical blanking flag from the line number.
// Assumes field-relative line numbers. Lines past the blanking
// interval are never blanked; the VBI window is freed by vbi_pass.
module vft_blank
    import vft_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic [LINE_W-1:0] line_i,
    input  vid_std_e          std,
    input  logic              vbi_pass,
    output logic              blank_o
);

    logic in_vbi;
    logic in_window;

    // Classify the current line against the standard's limits.
    always_comb begin
        in_vbi    = int'(line_i) <= vbi_last(std);
        in_window = (int'(line_i) >= pass_first(std)) && in_vbi;
        blank_o   = in_vbi && !(vbi_pass && in_window);
    end

endmodule

// File: rtl/vid_field_tracker.sv
// Module: top of the slave-timing line/field tracker. Detects sync
// edges, decides when resync is active, counts lines and fields, and
// decodes the VBI blanking flag. Assumes syncs are synchronous to clk.
module vid_field_tracker
    import vft_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [1:0]        std_sel_i,
    input  logic [MODE_W-1:0] slave_mode_i,
    input  logic              resync_en_i,
    input  logic              vbi_pass_i,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o,
    output logic              eof_o,
    output logic              blank_o
);

    logic [1:0] rise;
    logic       resync_act;
    vid_std_e   std;

    assign std        = vid_std_e'(std_sel_i);
    assign resync_act = resync_en_i && (slave_mode_i != '0);

    vft_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({vsync_i, hsync_i}),
        .rise_o (rise)
    );

    vft_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_rise    (rise[0]),
        .vs_rise    (rise[1]),
        .std        (std),
        .resync_act (resync_act),
        .line_o     (line_o),
        .field_o    (field_o),
        .eof_o      (eof_o)
    );

    vft_blank #(.LINE_W(LINE_W)) u_blank (
        .line_i   (line_o),
        .std      (std),
        .vbi_pass (vbi_pass_i),
        .blank_o  (blank_o)
    );

    assert_active_unblanked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(line_o) > 43) |-> !blank_o);

    assert_first_line_blanked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == LINE_W'(1)) |-> blank_o);

endmodule

// File: tb/tb_vid_field_tracker.sv
module tb_vid_field_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic [1:0] std_sel = 2'd0;
    logic [1:0] mode = 2'd0;
    logic       resync_en = 1'b0;
    logic       vbi_pass = 1'b0;
    logic [9:0] line;
    logic       field;
    logic       eof;
    logic       blank;

    int compared = 0;
    int mismatched = 0;
    logic seen_eof;

    always #2 clk = ~clk;

    vid_field_tracker dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hsync_i      (hsync),
        .vsync_i      (vsync),
        .std_sel_i    (std_sel),
        .slave_mode_i (mode),
        .resync_en_i  (resync_en),
        .vbi_pass_i   (vbi_pass),
        .line_o       (line),
        .field_o      (field),
        .eof_o        (eof),
        .blank_o      (blank)
    );

    // {std[1:0], vbi_pass, line[9:0], expected blank}
    localparam int NV = 22;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 1'b0, 10'd10, 1'b1}, {2'd0, 1'b0, 10'd20, 1'b1},
        {2'd0, 1'b0, 10'd21, 1'b0}, {2'd0, 1'b1, 10'd9,  1'b1},
        {2'd0, 1'b1, 10'd10, 1'b0}, {2'd0, 1'b1, 10'd20, 1'b0},
        {2'd0, 1'b1, 10'd21, 1'b0}, {2'd1, 1'b1, 10'd6,  1'b1},
        {2'd1, 1'b1, 10'd7,  1'b0}, {2'd1, 1'b1, 10'd22, 1'b0},
        {2'd1, 1'b0, 10'd22, 1'b1}, {2'd1, 1'b0, 10'd23, 1'b0},
        {2'd2, 1'b1, 10'd12, 1'b1}, {2'd2, 1'b1, 10'd13, 1'b0},
        {2'd2, 1'b1, 10'd42, 1'b0}, {2'd2, 1'b0, 10'd42, 1'b1},
        {2'd2, 1'b0, 10'd43, 1'b0}, {2'd3, 1'b1, 10'd5,  1'b1},
        {2'd3, 1'b1, 10'd6,  1'b0}, {2'd3, 1'b1, 10'd43, 1'b0},
        {2'd3, 1'b0, 10'd43, 1'b1}, {2'd3, 1'b1, 10'd44, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Each pulse task returns at the negedge after the sampling edge.
    task automatic hs_pulse();
        @(negedge clk) hsync = 1'b1;
        @(negedge clk) hsync = 1'b0;
        seen_eof = eof;
    endtask

    task automatic vs_pulse();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        seen_eof = eof;
    endtask

    task automatic both_pulse();
        @(negedge clk) begin hsync = 1'b1; vsync = 1'b1; end
        @(negedge clk) begin hsync = 1'b0; vsync = 1'b0; end
        seen_eof = eof;
    endtask

    task automatic hs_run(input int n);
        for (int i = 0; i < n; i++) hs_pulse();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 line", int'(line), 1);
        chk("R1 field", int'(field), 0);
        chk("R1 eof", int'(eof), 0);
        chk("R8 blank at line 1", int'(blank), 1);

        // R8 / R9 table walk over window edges
        for (int v = 0; v < NV; v++) begin
            std_sel  = VEC[v][13:12];
            vbi_pass = VEC[v][11];
            do_reset();
            hs_run(int'(VEC[v][10:1]) - 1);
            chk("R2 line count", int'(line), int'(VEC[v][10:1]));
            chk(VEC[v][11] ? "R9 blank window" : "R8 blank vbi", int'(blank), int'(VEC[v][0]));
        end
        vbi_pass = 1'b0;

        // R3: free-run wrap, interlaced 525
        std_sel = 2'd0;
        do_reset();
        hs_run(262);
        chk("R3 last line f0", int'(line), 263);
        hs_pulse();
        chk("R3 wrap line", int'(line), 1);
        chk("R3 field toggle", int'(field), 1);
        chk("R7 eof on wrap", int'(seen_eof), 1);
        @(negedge clk);
        chk("R7 eof one cycle", int'(eof), 0);
        hs_run(261);
        chk("R3 last line f1", int'(line), 262);
        hs_pulse();
        chk("R3 wrap to f0", int'(field), 0);
        chk("R3 wrap line f1", int'(line), 1);

        // R3: progressive field stays 0
        std_sel = 2'd2;
        do_reset();
        hs_run(525);
        chk("R3 prog wrap line", int'(line), 1);
        chk("R3 prog field", int'(field), 0);
        chk("R7 prog eof", int'(seen_eof), 1);

        // R4: resync requested but mode 0
        std_sel = 2'd0; resync_en = 1'b1; mode = 2'd0;
        do_reset();
        hs_run(5);
        vs_pulse();
        chk("R4 mode0 line", int'(line), 6);
        chk("R4 mode0 eof", int'(seen_eof), 0);
        hs_run(257);
        hs_pulse();
        chk("R4 mode0 wraps", int'(line), 1);
        chk("R4 mode0 field", int'(field), 1);

        // R4: resync disabled with a slave mode selected
        resync_en = 1'b0; mode = 2'd1;
        do_reset();
        hs_run(3);
        vs_pulse();
        chk("R4 disabled line", int'(line), 4);
        chk("R4 disabled field", int'(field), 0);

        // R5: fast forward, early vsync at line 100
        std_sel = 2'd1; resync_en = 1'b1; mode = 2'd2;
        do_reset();
        hs_run(99);
        vs_pulse();
        chk("R5 restart line", int'(line), 1);
        chk("R5 field toggle", int'(field), 1);
        chk("R5 eof", int'(seen_eof), 1);
        @(negedge clk);
        chk("R7 eof one cycle resync", int'(eof), 0);
        hs_pulse();
        chk("R5 count after restart", int'(line), 2);

        // R6: rewind, late vsync after the field's last line
        hs_run(310);
        chk("R6 last line", int'(line), 312);
        for (int k = 0; k < 3; k++) begin
            hs_pulse();
            chk("R6 hold line", int'(line), 312);
            chk("R6 no eof", int'(seen_eof), 0);
        end
        vs_pulse();
        chk("R6 late restart", int'(line), 1);
        chk("R6 field", int'(field), 0);
        chk("R6 eof", int'(seen_eof), 1);

        // R7: coincident hsync and vsync
        hs_run(10);
        both_pulse();
        chk("R7 coincident line", int'(line), 1);
        chk("R7 coincident field", int'(field), 1);
        chk("R7 coincident eof", int'(seen_eof), 1);
        @(negedge clk);
        chk("R7 coincident single", int'(eof), 0);

        // R5: progressive resync keeps field 0
        std_sel = 2'd3;
        do_reset();
        hs_run(40);
        vs_pulse();
        chk("R5 prog line", int'(line), 1);
        chk("R5 prog field", int'(field), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule